// File: doc/BRIEF.md
# Noise Histogram Measurement Engine

This block builds a histogram of received noise power over a programmed measurement window. On each sample tick it takes an 8-bit power estimate and places it in one of twelve bins. The bin edges are eleven programmable 8-bit thresholds. Each sample can be gated by two activity flags: channel busy and transmitter on. For each flag, a control bit selects whether samples taken while that flag is high are counted or dropped.

Configuration arrives as five 32-bit register-style words: three threshold words, a control word and a period word. Software starts a measurement by taking the trigger bit of the control word low and then high. The engine acts only on the rising edge of that bit. It counts sample ticks until the programmed window length is reached. It then raises a ready flag and freezes its results.

The results are read as three 32-bit bin-count words and a status word. The status word carries the ready flag and the number of samples that were actually binned.

Top module: `noise_hist_engine`

## Requirements
- R1: After reset, all twelve bin counts, the duration field and the ready flag read zero.
- R2: A sample goes to bin k (1..10) when its power is at or above threshold k-1 and below threshold k. Bin 0 takes power below threshold 0. Bin 11 takes power at or above threshold 10. Thresholds are assumed ascending.
- R3: Threshold byte locations are as follows. Thresholds 0..3 are bytes 0..3 of `thr_lo_word`. Thresholds 4..7 are bytes 0..3 of `thr_mid_word`. Threshold 8 is byte 0 of `thr_hi_word`. Thresholds 9 and 10 are bytes 2 and 3 of `ctrl_word`.
- R4: A 0-to-1 transition of `ctrl_word[1]` clears every bin count, the duration field and the ready flag, and starts a measurement. Holding the bit high does not restart it.
- R5: The window length is latched from `period_word[31:16]` at the trigger edge. After that many counted ticks, ready (`status_word[17]`) rises one cycle after the last tick. Later ticks change nothing until the next trigger.
- R6: `status_word[15:0]` holds the number of samples binned in the current measurement. All other status bits except bit 17 read zero.
- R7: With `ctrl_word[9]` = 1, samples taken while `cca_busy` is high are binned. With it at 0, they are dropped: no bin and no duration increment. They still advance the window.
- R8: `ctrl_word[10]` controls samples taken while `tx_on` is high, in the same way R7 describes for `cca_busy`.
- R9: While the enable bit `ctrl_word[8]` is 0, sample ticks are ignored entirely. Bins, duration and the window position all stay unchanged.
- R10: Each bin count saturates at 255 and does not wrap.
- R11: Bin k is read from byte k%4 of `bins_word0`, `bins_word1` or `bins_word2`, selected by k/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle strobe marking a power sample (nominally every 4 us) |
| power | input | 8 | Noise power estimate for the current sample |
| cca_busy | input | 1 | Channel-busy indication |
| tx_on | input | 1 | Transmitter-active indication |
| thr_lo_word | input | 32 | Thresholds 0..3, one per byte |
| thr_mid_word | input | 32 | Thresholds 4..7, one per byte |
| thr_hi_word | input | 32 | Threshold 8 in byte 0 |
| ctrl_word | input | 32 | Bit 1 trigger, bit 8 enable, bit 9 busy include, bit 10 tx include, bytes 2/3 thresholds 9/10 |
| period_word | input | 32 | Window length in ticks in bits 31:16 |
| bins_word0 | output | 32 | Bin counts 0..3 |
| bins_word1 | output | 32 | Bin counts 4..7 |
| bins_word2 | output | 32 | Bin counts 8..11 |
| status_word | output | 32 | Duration in bits 15:0, ready in bit 17 |

## Verification
The bench builds the engine with its default parameters: eleven 8-bit thresholds, twelve 8-bit saturating bins and a 16-bit duration. With these values a 300-tick window drives one bin past 255, so saturation is reached in a short run. A 24-tick sweep of powers in steps of 5 lands on every threshold exactly and fills every bin twice. Short windows with flag patterns, a disabled phase and a mid-run retrigger exercise the gating and restart corners against a behavioural model compared every clock.

// File: rtl/nhe_pkg.sv
package nhe_pkg;
  localparam int NHE_THR_N  = 11;
  localparam int NHE_BIN_N  = NHE_THR_N + 1;
  localparam int NHE_PWR_W  = 8;
  localparam int NHE_CNT_W  = 8;
  localparam int NHE_DUR_W  = 16;
  localparam int NHE_WORD_W = 32;
  // control word bit positions decoded by the engine
  localparam int NHE_TRIG_BIT  = 1;
  localparam int NHE_EN_BIT    = 8;
  localparam int NHE_CCA_BIT   = 9;
  localparam int NHE_TX_BIT    = 10;
  localparam int NHE_READY_BIT = 17;
endpackage

// File: rtl/nhe_bin_sel.sv
module nhe_bin_sel #(
  parameter int NUM_THR = 11,
  parameter int PWR_W   = 8
) (
  input  logic [NUM_THR*PWR_W-1:0] thr_flat,
  input  logic [PWR_W-1:0]         power,
  output logic [NUM_THR:0]         bin_hot
);
  localparam int IDX_W = $clog2(NUM_THR + 1);

  logic [NUM_THR-1:0] at_or_above;
  logic [IDX_W-1:0]   bin_idx;

  for (genvar k = 0; k < NUM_THR; k++) begin : g_cmp
    assign at_or_above[k] = (power >= thr_flat[k*PWR_W +: PWR_W]);
  end

  // with ascending edges the bin index equals the number of edges passed
  always_comb begin
    bin_idx = '0;
    for (int k = 0; k < NUM_THR; k++) begin
      bin_idx = bin_idx + IDX_W'(at_or_above[k]);
    end
  end

  always_comb begin
    bin_hot = '0;
    bin_hot[bin_idx] = 1'b1;
  end
endmodule

// File: rtl/nhe_sat_cnt.sv
module nhe_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != CNT_MAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/nhe_window.sv
module nhe_window #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_lvl,
  input  logic             enable,
  input  logic             tick,
  input  logic             accept,
  input  logic [DUR_W-1:0] period,
  output logic             clr_pulse,
  output logic             bin_go,
  output logic             ready,
  output logic [DUR_W-1:0] duration
);
  logic             trig_q, run_q, run_d, rdy_q, rdy_d;
  logic [DUR_W-1:0] win_q, win_d, lim_q, dur_q, dur_d;
  logic             at_end, sample_go;

  always_comb begin
    clr_pulse = trig_lvl & ~trig_q;
    at_end    = (win_q == lim_q);
    sample_go = run_q & enable & tick & ~at_end & ~clr_pulse;
    bin_go    = sample_go & accept;
    run_d = run_q;
    rdy_d = rdy_q;
    win_d = win_q;
    dur_d = dur_q;
    if (clr_pulse) begin
      run_d = 1'b1;
      rdy_d = 1'b0;
      win_d = '0;
      dur_d = '0;
    end else if (run_q && at_end) begin
      run_d = 1'b0;
      rdy_d = 1'b1;
    end else if (sample_go) begin
      win_d = win_q + 1'b1;
      if (accept) dur_d = dur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
      win_q  <= '0;
      dur_q  <= '0;
      lim_q  <= '0;
    end else begin
      trig_q <= trig_lvl;
      run_q  <= run_d;
      rdy_q  <= rdy_d;
      win_q  <= win_d;
      dur_q  <= dur_d;
      if (clr_pulse) lim_q <= period;
    end
  end

  assign ready    = rdy_q;
  assign duration = dur_q;

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> !run_q);
  // R4
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (!rdy_q && dur_q == '0 && run_q));
  // R6
  dur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dur_q <= win_q);
  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clr_pulse) |=> $stable(win_q));
endmodule

// File: rtl/noise_hist_engine.sv
module noise_hist_engine
  import nhe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_tick,
  input  logic [7:0]  power,
  input  logic        cca_busy,
  input  logic        tx_on,
  input  logic [31:0] thr_lo_word,
  input  logic [31:0] thr_mid_word,
  input  logic [31:0] thr_hi_word,
  input  logic [31:0] ctrl_word,
  input  logic [31:0] period_word,
  output logic [31:0] bins_word0,
  output logic [31:0] bins_word1,
  output logic [31:0] bins_word2,
  output logic [31:0] status_word
);
  localparam int THR_FLAT_W = NHE_THR_N * NHE_PWR_W;
  localparam int BIN_FLAT_W = NHE_BIN_N * NHE_CNT_W;

  logic [THR_FLAT_W-1:0] thr_flat;
  logic [NHE_BIN_N-1:0]  bin_hot;
  logic [BIN_FLAT_W-1:0] bin_flat;
  logic                  accept, clr_pulse, bin_go, ready;
  logic [NHE_DUR_W-1:0]  duration;
  logic                  cfg_unused;

  // thresholds 0..10 gathered lowest-first from their register bytes
  assign thr_flat = {ctrl_word[31:16], thr_hi_word[7:0], thr_mid_word, thr_lo_word};
  assign cfg_unused = ^{thr_hi_word[31:8], period_word[15:0], ctrl_word[15:11],
                        ctrl_word[7:2], ctrl_word[0]};

  assign accept = (~cca_busy | ctrl_word[NHE_CCA_BIT]) &
                  (~tx_on    | ctrl_word[NHE_TX_BIT]);

  nhe_bin_sel #(.NUM_THR(NHE_THR_N), .PWR_W(NHE_PWR_W)) u_sel (
    .thr_flat (thr_flat),
    .power    (power),
    .bin_hot  (bin_hot)
  );

  nhe_window #(.DUR_W(NHE_DUR_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_lvl  (ctrl_word[NHE_TRIG_BIT]),
    .enable    (ctrl_word[NHE_EN_BIT]),
    .tick      (sample_tick),
    .accept    (accept),
    .period    (period_word[31:16]),
    .clr_pulse (clr_pulse),
    .bin_go    (bin_go),
    .ready     (ready),
    .duration  (duration)
  );

  for (genvar b = 0; b < NHE_BIN_N; b++) begin : g_bin
    nhe_sat_cnt #(.CNT_W(NHE_CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_pulse),
      .inc   (bin_go & bin_hot[b]),
      .cnt   (bin_flat[b*NHE_CNT_W +: NHE_CNT_W])
    );
  end

  assign bins_word0 = bin_flat[31:0];
  assign bins_word1 = bin_flat[63:32];
  assign bins_word2 = bin_flat[95:64];

  always_comb begin
    status_word = '0;
    status_word[NHE_DUR_W-1:0] = duration;
    status_word[NHE_READY_BIT] = ready;
  end

  // R2
  one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bin_hot) == 1);
  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cca_busy && !ctrl_word[NHE_CCA_BIT] && !clr_pulse) |=> $stable(status_word[15:0]));
endmodule

// File: tb/noise_hist_engine_tb.sv
module noise_hist_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_tick = 1'b0;
  logic [7:0]  power = '0;
  logic        cca_busy = 1'b0, tx_on = 1'b0;
  logic [7:0]  thr [11];
  logic        trig = 1'b0, en = 1'b0, cca_inc = 1'b1, tx_inc = 1'b1;
  logic [15:0] period = '0;
  logic [31:0] thr_lo_word, thr_mid_word, thr_hi_word, ctrl_word, period_word;
  logic [31:0] bins_word0, bins_word1, bins_word2, status_word;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;

  // reference state
  int m_bin [12];
  int m_dur, m_win, m_lim;
  bit m_run, m_rdy, m_trig;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign thr_lo_word  = {thr[3], thr[2], thr[1], thr[0]};
  assign thr_mid_word = {thr[7], thr[6], thr[5], thr[4]};
  assign thr_hi_word  = {24'h0, thr[8]};
  assign ctrl_word    = {thr[10], thr[9], 5'b0, tx_inc, cca_inc, en, 6'b0, trig, 1'b0};
  assign period_word  = {period, 16'h0};

  noise_hist_engine u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .power(power),
    .cca_busy(cca_busy), .tx_on(tx_on), .thr_lo_word(thr_lo_word),
    .thr_mid_word(thr_mid_word), .thr_hi_word(thr_hi_word), .ctrl_word(ctrl_word),
    .period_word(period_word), .bins_word0(bins_word0), .bins_word1(bins_word1),
    .bins_word2(bins_word2), .status_word(status_word)
  );

  function automatic int ref_bin(input int p);
    for (int k = 0; k < 11; k++) if (p < int'(thr[k])) return k;
    return 11;
  endfunction

  function automatic logic [31:0] ref_word(input int w);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = 8'(m_bin[w*4+j]);
    return r;
  endfunction

  function automatic logic [31:0] ref_status();
    logic [31:0] r = '0;
    r[15:0] = 16'(m_dur);
    r[17]   = m_rdy;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_bin[i]) m_bin[i] = 0;
      m_dur = 0; m_win = 0; m_lim = 0; m_run = 0; m_rdy = 0; m_trig = 0;
    end else begin
      if (trig && !m_trig) begin
        foreach (m_bin[i]) m_bin[i] = 0;
        m_dur = 0; m_win = 0; m_lim = int'(period); m_run = 1; m_rdy = 0;
      end else if (m_run && m_win == m_lim) begin
        m_run = 0; m_rdy = 1;
      end else if (m_run && en && sample_tick) begin
        m_win++;
        if ((!cca_busy || cca_inc) && (!tx_on || tx_inc)) begin
          m_dur++;
          if (m_bin[ref_bin(int'(power))] < 255) m_bin[ref_bin(int'(power))]++;
        end
      end
      m_trig = trig;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bins_word0 == ref_word(0), "R2", bins_word0, ref_word(0));
      chk(bins_word1 == ref_word(1), "R2", bins_word1, ref_word(1));
      chk(bins_word2 == ref_word(2), "R2", bins_word2, ref_word(2));
      chk(status_word == ref_status(), "R6", status_word, ref_status());
    end
  end

  task automatic do_tick(input logic [7:0] p, input bit cb, input bit tx);
    power = p; cca_busy = cb; tx_on = tx; sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0; cca_busy = 1'b0; tx_on = 1'b0;
    @(negedge clk);
  endtask

  task automatic start(input logic [15:0] len);
    period = len; trig = 1'b0;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 20 && !status_word[17]; i++) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 11; k++) thr[k] = 8'(10 + 10*k);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bins_word0 == 0 && bins_word1 == 0 && bins_word2 == 0, "R1", bins_word0, 0);
    chk(status_word == 0, "R1", status_word, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R11 sweep across every threshold exactly
    en = 1'b1;
    start(16'd24);
    for (int i = 0; i < 24; i++) do_tick(8'(i*5), 1'b0, 1'b0);
    wait_ready();
    chk(bins_word0 == 32'h02020202, "R11", bins_word0, 32'h02020202);
    chk(bins_word1 == 32'h02020202, "R3", bins_word1, 32'h02020202);
    chk(bins_word2 == 32'h02020202, "R2", bins_word2, 32'h02020202);
    chk(status_word == 32'h00020018, "R5", status_word, 32'h00020018);

    // R7 busy samples dropped
    cca_inc = 1'b0;
    start(16'd8);
    for (int i = 0; i < 8; i++) do_tick(8'd50, i[0], 1'b0);
    wait_ready();
    chk(bins_word1 == 32'h00000400, "R7", bins_word1, 32'h00000400);
    chk(status_word == 32'h00020004, "R7", status_word, 32'h00020004);

    // R8 transmit samples dropped, busy now included
    cca_inc = 1'b1; tx_inc = 1'b0;
    start(16'd6);
    for (int i = 0; i < 6; i++) do_tick(8'd200, 1'b1, i < 2);
    wait_ready();
    chk(bins_word2 == 32'h04000000, "R8", bins_word2, 32'h04000000);
    chk(status_word == 32'h00020004, "R8", status_word, 32'h00020004);
    tx_inc = 1'b1;

    // R9 disabled ticks ignored
    en = 1'b0;
    start(16'd3);
    for (int i = 0; i < 5; i++) do_tick(8'd0, 1'b0, 1'b0);
    chk(status_word == 0 && bins_word0 == 0, "R9", status_word, 0);
    en = 1'b1;
    for (int i = 0; i < 3; i++) do_tick(8'd0, 1'b0, 1'b0);
    wait_ready();
    chk(bins_word0 == 32'h00000003, "R9", bins_word0, 32'h00000003);
    chk(status_word == 32'h00020003, "R5", status_word, 32'h00020003);

    // R10 saturation in a long window
    start(16'd300);
    for (int i = 0; i < 300; i++) do_tick(8'd0, 1'b0, 1'b0);
    wait_ready();
    chk(bins_word0 == 32'h000000FF, "R10", bins_word0, 32'h000000FF);
    chk(status_word == 32'h0002012C, "R10", status_word, 32'h0002012C);

    // R4 retrigger mid-run clears; holding high does not restart
    start(16'd10);
    for (int i = 0; i < 4; i++) do_tick(8'd30, 1'b0, 1'b0);
    start(16'd10);
    chk(status_word == 0 && bins_word0 == 0, "R4", status_word, 0);
    for (int i = 0; i < 10; i++) do_tick(8'd30, 1'b0, 1'b0);
    wait_ready();
    chk(status_word == 32'h0002000A, "R4", status_word, 32'h0002000A);
    // R5 ticks after completion change nothing
    for (int i = 0; i < 3; i++) do_tick(8'd30, 1'b0, 1'b0);
    chk(status_word == 32'h0002000A, "R5", status_word, 32'h0002000A);
    chk(bins_word0 == 32'h0A000000, "R2", bins_word0, 32'h0A000000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule